// File: doc/BRIEF.md
# BCD Calendar Counter with 12/24-Hour Mode

This block holds the wall-clock time and the calendar date as packed BCD bytes and advances them by one second on each pulse of a 1 Hz tick. A carry passes upward from seconds through minutes and hours into the day-of-week, date, month and two-digit year fields. The month length follows the calendar, and February is lengthened in leap years.

The hour byte carries its own format. Bit 6 selects 12-hour counting, with bit 5 as the afternoon flag. When bit 6 is clear the hour counts 0 to 23. A host can overwrite any single field in any cycle through a field-select load port. A load always wins over the tick for the field it writes.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hour 00 (24-hour format), day of week 1, date 01, month 01 and year 00.
- R2: Each tick adds one to seconds. Seconds wrap from 59 to 00 and then add one to minutes. Minutes wrap from 59 to 00 and then carry into the hour.
- R3: With hour bit 6 clear, bits 5:0 count in BCD from 00 to 23. A carry at 23 gives 00 and advances the day.
- R4: With hour bit 6 set, bits 4:0 count in BCD from 1 to 12 and bit 5 is the PM flag. A carry at 11 gives 12 and inverts the flag. A carry at 12 gives 1 and keeps the flag. The day advances only on the step from 11 PM to 12 AM.
- R5: The day of week counts 1 to 7 and wraps from 7 back to 1 on each day carry.
- R6: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in every other month except 02.
- R7: February ends after day 29 when the BCD year is a multiple of four, and after day 28 otherwise.
- R8: A month carry at 12 gives 01 and advances the year. The year wraps from 99 to 00.
- R9: A load with ldValid high writes ldData into the field picked by ldField on the next edge. The codes are 0 seconds, 1 minutes, 2 hour, 3 day of week, 4 date, 5 month, 6 year. Only the low 7, 7, 7, 3, 6, 5 or 8 bits of each field are stored, and the unused upper bits read 0. Code 7 changes nothing.
- R10: When a load and a tick arrive together, the loaded field takes the load value and drops its tick step. All other fields advance using carries computed from the values held before that edge.
- R11: With no tick and no load, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickSec | input | 1 | One-cycle pulse, once per second |
| ldValid | input | 1 | Host load strobe |
| ldField | input | 3 | Field code for the load |
| ldData | input | 8 | BCD value to load |
| secOut | output | 8 | Seconds |
| minOut | output | 8 | Minutes |
| hourOut | output | 8 | Hour with format and PM bits |
| dowOut | output | 8 | Day of week |
| dateOut | output | 8 | Day of month |
| monthOut | output | 8 | Month |
| yearOut | output | 8 | Two-digit year |

## Verification
The hardest states to reach are the rare carries: a leap-year February 29, the year wrap, and the 11-to-12 step with its PM flip. Counting into them with ticks alone would take millions of cycles. The stimulus instead uses the load port to place every field one second before the boundary, then issues a single tick. The bench also fires a load and a tick in the same cycle to show that the loaded field wins and that the carries still come from the old values.

// File: rtl/bcal_pkg.sv
package bcal_pkg;
  localparam int NUM_FIELDS  = 7;
  localparam int FIELD_SEL_W = $clog2(NUM_FIELDS + 1);
  localparam int REG_W       = 8;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DOW  = 3;
  localparam int IDX_DATE = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;

  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 7;
  localparam int DOW_W  = 3;
  localparam int DATE_W = 6;
  localparam int MON_W  = 5;
  localparam int YEAR_W = 8;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] load;
    logic [NUM_FIELDS-1:0] step;
  } calStrobe_t;

  typedef struct packed {
    logic secEnd;
    logic minEnd;
    logic hourEnd;
    logic dateEnd;
    logic monEnd;
  } calStatus_t;

  function automatic logic [REG_W-1:0] widthMask(input int w);
    return REG_W'((1 << w) - 1);
  endfunction

  function automatic logic [REG_W-1:0] fieldMask(input int idx);
    case (idx)
      IDX_SEC:  return widthMask(SEC_W);
      IDX_MIN:  return widthMask(MIN_W);
      IDX_HOUR: return widthMask(HOUR_W);
      IDX_DOW:  return widthMask(DOW_W);
      IDX_DATE: return widthMask(DATE_W);
      IDX_MON:  return widthMask(MON_W);
      default:  return widthMask(YEAR_W);
    endcase
  endfunction

  function automatic logic [REG_W-1:0] fieldReset(input int idx);
    return (idx == IDX_DOW || idx == IDX_DATE || idx == IDX_MON) ? REG_W'(1) : '0;
  endfunction

  // Adds one to a two-digit packed BCD value, carrying at a units digit of 9.
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction
endpackage

// File: rtl/bcal_ctrl.sv
module bcal_ctrl
  import bcal_pkg::*;
(
  input  logic                   tickSec,
  input  logic                   ldValid,
  input  logic [FIELD_SEL_W-1:0] ldField,
  input  calStatus_t             status,
  output calStrobe_t             strobe
);
  logic [NUM_FIELDS-1:0] loadVec;
  logic [NUM_FIELDS-1:0] stepVec;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    assign loadVec[i] = ldValid && (ldField == FIELD_SEL_W'(i));
  end

  // Ripple of carries: each field steps when every field below it wraps.
  always_comb begin
    stepVec           = '0;
    stepVec[IDX_SEC]  = tickSec;
    stepVec[IDX_MIN]  = stepVec[IDX_SEC]  && status.secEnd;
    stepVec[IDX_HOUR] = stepVec[IDX_MIN]  && status.minEnd;
    stepVec[IDX_DOW]  = stepVec[IDX_HOUR] && status.hourEnd;
    stepVec[IDX_DATE] = stepVec[IDX_HOUR] && status.hourEnd;
    stepVec[IDX_MON]  = stepVec[IDX_DATE] && status.dateEnd;
    stepVec[IDX_YEAR] = stepVec[IDX_MON]  && status.monEnd;
  end

  assign strobe = '{load: loadVec, step: stepVec};
endmodule

// File: rtl/bcal_dpath.sv
module bcal_dpath
  import bcal_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  calStrobe_t                          strobe,
  input  logic [REG_W-1:0]                    ldData,
  output logic [NUM_FIELDS-1:0][REG_W-1:0]    fieldVal,
  output calStatus_t                          status
);
  logic [REG_W-1:0] fieldQ  [NUM_FIELDS];
  logic [REG_W-1:0] nextVal [NUM_FIELDS];

  logic [REG_W-1:0] secQ, minQ, hourQ, dowQ, dateQ, monQ, yearQ;
  assign secQ  = fieldQ[IDX_SEC];
  assign minQ  = fieldQ[IDX_MIN];
  assign hourQ = fieldQ[IDX_HOUR];
  assign dowQ  = fieldQ[IDX_DOW];
  assign dateQ = fieldQ[IDX_DATE];
  assign monQ  = fieldQ[IDX_MON];
  assign yearQ = fieldQ[IDX_YEAR];

  logic             mode12;
  logic             isLeap;
  logic [1:0]       leapSum;
  logic [REG_W-1:0] monthLen;
  logic [REG_W-1:0] hInc12, hInc24;

  assign mode12  = hourQ[6];
  // year mod 4 equals (2*tens + ones) mod 4
  assign leapSum = yearQ[1:0] + {yearQ[4], 1'b0};
  assign isLeap  = (leapSum == 2'b00);
  assign hInc12  = bcdInc(hourQ & 8'h1f);
  assign hInc24  = bcdInc(hourQ & 8'h3f);

  always_comb begin
    case (monQ)
      8'h02:                      monthLen = isLeap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: monthLen = 8'h30;
      default:                    monthLen = 8'h31;
    endcase
  end

  always_comb begin
    status.secEnd  = secQ  >= 8'h59;
    status.minEnd  = minQ  >= 8'h59;
    status.hourEnd = mode12 ? (hourQ[5] && hourQ[4:0] == 5'h11) : (hourQ[5:0] >= 6'h23);
    status.dateEnd = dateQ >= monthLen;
    status.monEnd  = monQ  >= 8'h12;
  end

  always_comb begin
    nextVal[IDX_SEC]  = status.secEnd ? 8'h00 : bcdInc(secQ);
    nextVal[IDX_MIN]  = status.minEnd ? 8'h00 : bcdInc(minQ);
    if (mode12) begin
      if (hourQ[4:0] == 5'h12)      nextVal[IDX_HOUR] = (hourQ & 8'h60) | 8'h01;
      else if (hourQ[4:0] == 5'h11) nextVal[IDX_HOUR] = (hourQ & 8'h40) | (~hourQ & 8'h20) | 8'h12;
      else                          nextVal[IDX_HOUR] = (hourQ & 8'h60) | hInc12;
    end else begin
      nextVal[IDX_HOUR] = (hourQ[5:0] >= 6'h23) ? 8'h00 : hInc24;
    end
    nextVal[IDX_DOW]  = (dowQ >= 8'h07) ? 8'h01 : dowQ + 8'h01;
    nextVal[IDX_DATE] = status.dateEnd ? 8'h01 : bcdInc(dateQ);
    nextVal[IDX_MON]  = status.monEnd ? 8'h01 : bcdInc(monQ);
    nextVal[IDX_YEAR] = (yearQ >= 8'h99) ? 8'h00 : bcdInc(yearQ);
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                fieldQ[i] <= fieldReset(i);
      else if (strobe.load[i])  fieldQ[i] <= ldData & fieldMask(i);
      else if (strobe.step[i])  fieldQ[i] <= nextVal[i];
    end
    assign fieldVal[i] = fieldQ[i];
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcal_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickSec,
  input  logic                   ldValid,
  input  logic [FIELD_SEL_W-1:0] ldField,
  input  logic [REG_W-1:0]       ldData,
  output logic [REG_W-1:0]       secOut,
  output logic [REG_W-1:0]       minOut,
  output logic [REG_W-1:0]       hourOut,
  output logic [REG_W-1:0]       dowOut,
  output logic [REG_W-1:0]       dateOut,
  output logic [REG_W-1:0]       monthOut,
  output logic [REG_W-1:0]       yearOut
);
  calStrobe_t                       strobe;
  calStatus_t                       status;
  logic [NUM_FIELDS-1:0][REG_W-1:0] fieldVal;

  bcal_ctrl u_ctrl (
    .tickSec (tickSec),
    .ldValid (ldValid),
    .ldField (ldField),
    .status  (status),
    .strobe  (strobe)
  );

  bcal_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ldData   (ldData),
    .fieldVal (fieldVal),
    .status   (status)
  );

  assign secOut   = fieldVal[IDX_SEC];
  assign minOut   = fieldVal[IDX_MIN];
  assign hourOut  = fieldVal[IDX_HOUR];
  assign dowOut   = fieldVal[IDX_DOW];
  assign dateOut  = fieldVal[IDX_DATE];
  assign monthOut = fieldVal[IDX_MON];
  assign yearOut  = fieldVal[IDX_YEAR];
endmodule

// File: rtl/bcal_checker.sv
module bcal_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tickSec,
  input logic       ldValid,
  input logic [2:0] ldField,
  input logic [7:0] ldData,
  input logic [7:0] secOut,
  input logic [7:0] minOut,
  input logic [7:0] hourOut,
  input logic [7:0] dowOut,
  input logic [7:0] dateOut,
  input logic [7:0] monthOut,
  input logic [7:0] yearOut
);
  logic lastSecond;
  assign lastSecond = tickSec && !ldValid && secOut == 8'h59 && minOut == 8'h59;

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    tickSec && !ldValid && secOut == 8'h59 |=> secOut == 8'h00);

  p_min_carry_r2: assert property (@(posedge clk) disable iff (!rstN)
    tickSec && !ldValid && secOut == 8'h59 && minOut != 8'h59 |=> minOut != $past(minOut));

  p_midnight_r3: assert property (@(posedge clk) disable iff (!rstN)
    lastSecond && hourOut == 8'h23 |=> hourOut == 8'h00);

  p_noon_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    lastSecond && hourOut == 8'h51 |=> hourOut == 8'h72);

  p_dow_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    lastSecond && hourOut == 8'h23 && dowOut == 8'h07 |=> dowOut == 8'h01);

  p_year_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    lastSecond && hourOut == 8'h23 && dateOut == 8'h31 && monthOut == 8'h12 && yearOut == 8'h99
    |=> yearOut == 8'h00 && monthOut == 8'h01);

  p_load_sec_r9: assert property (@(posedge clk) disable iff (!rstN)
    ldValid && ldField == 3'd0 |=> secOut == ($past(ldData) & 8'h7f));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !tickSec && !ldValid |=> $stable(secOut) && $stable(minOut) && $stable(hourOut) &&
      $stable(dowOut) && $stable(dateOut) && $stable(monthOut) && $stable(yearOut));
endmodule

bind bcd_calendar bcal_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickSec  (tickSec),
  .ldValid  (ldValid),
  .ldField  (ldField),
  .ldData   (ldData),
  .secOut   (secOut),
  .minOut   (minOut),
  .hourOut  (hourOut),
  .dowOut   (dowOut),
  .dateOut  (dateOut),
  .monthOut (monthOut),
  .yearOut  (yearOut)
);

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickSec = 1'b0;
  logic       ldValid = 1'b0;
  logic [2:0] ldField = 3'd0;
  logic [7:0] ldData = 8'h00;
  logic [7:0] secOut, minOut, hourOut, dowOut, dateOut, monthOut, yearOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [55:0] expQ[$];
  string       tagQ[$];
  logic [55:0] modelSt;

  always #2 clk = ~clk;

  bcd_calendar u_dut (
    .clk(clk), .rstN(rstN), .tickSec(tickSec), .ldValid(ldValid),
    .ldField(ldField), .ldData(ldData), .secOut(secOut), .minOut(minOut),
    .hourOut(hourOut), .dowOut(dowOut), .dateOut(dateOut),
    .monthOut(monthOut), .yearOut(yearOut)
  );

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic logic [7:0] maskOf(input int f);
    case (f)
      0, 1, 2: return 8'h7f;
      3:       return 8'h07;
      4:       return 8'h3f;
      5:       return 8'h1f;
      default: return 8'hff;
    endcase
  endfunction

  // Reference model: arithmetic done in binary, 12-hour mapped through 0..23.
  function automatic logic [55:0] model(input logic [55:0] st, input bit tk,
                                        input bit v, input int f, input logic [7:0] d);
    int s, mi, h24, h12, dw, dt, mo, yr, dim;
    bit twelve, pm;
    logic [7:0] hb, tmp;
    logic [55:0] r;
    s  = b2i(st[7:0]);   mi = b2i(st[15:8]);  hb = st[23:16];
    dw = int'(st[31:24]); dt = b2i(st[39:32]); mo = b2i(st[47:40]); yr = b2i(st[55:48]);
    twelve = hb[6]; pm = hb[5];
    if (twelve) begin
      h12 = b2i({3'b000, hb[4:0]});
      h24 = (h12 % 12) + (pm ? 12 : 0);
    end else h24 = b2i({2'b00, hb[5:0]});
    if (tk) begin
      s++;
      if (s == 60) begin
        s = 0; mi++;
        if (mi == 60) begin
          mi = 0; h24++;
          if (h24 == 24) begin
            h24 = 0;
            dw = (dw == 7) ? 1 : dw + 1;
            if (mo == 2) dim = (yr % 4 == 0) ? 29 : 28;
            else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) dim = 30;
            else dim = 31;
            dt++;
            if (dt > dim) begin
              dt = 1; mo++;
              if (mo > 12) begin mo = 1; yr = (yr + 1) % 100; end
            end
          end
        end
      end
    end
    if (twelve) begin
      h12 = h24 % 12;
      if (h12 == 0) h12 = 12;
      tmp = i2b(h12);
      hb = {2'b01, (h24 >= 12) ? 1'b1 : 1'b0, tmp[4:0]};
    end else hb = i2b(h24);
    r = {i2b(yr), i2b(mo), i2b(dt), 8'(dw), hb, i2b(mi), i2b(s)};
    if (v && f < 7) r[8*f +: 8] = d & maskOf(f);
    return r;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected state.
  task automatic drive(input bit tk, input bit v, input int f, input logic [7:0] d, input string tag);
    tickSec = tk; ldValid = v; ldField = 3'(f); ldData = d;
    modelSt = model(modelSt, tk, v, f, d);
    @(posedge clk);
    expQ.push_back(modelSt);
    tagQ.push_back(tag);
    @(negedge clk);
    tickSec = 1'b0; ldValid = 1'b0;
  endtask

  task automatic put(input int f, input logic [7:0] d);
    drive(1'b0, 1'b1, f, d, "R9");
  endtask

  task automatic setClock(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    put(2, h); put(1, m); put(0, s);
  endtask

  task automatic setDate(input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr);
    put(4, dt); put(5, mo); put(6, yr);
  endtask

  // Monitor: pops one expectation per cycle, sampled at the falling edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [55:0] e, a;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = {yearOut, monthOut, dateOut, dowOut, hourOut, minOut, secOut};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    modelSt = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    drive(1'b0, 1'b0, 0, 8'h00, "R1");

    // R8 R3: full rollover at the end of a century
    setClock(8'h23, 8'h59, 8'h59); put(3, 8'h03); setDate(8'h31, 8'h12, 8'h99);
    drive(1'b1, 1'b0, 0, 8'h00, "R8");
    // R9: code 7 ignored, upper bits masked
    drive(1'b0, 1'b1, 7, 8'hAA, "R9");
    drive(1'b0, 1'b1, 3, 8'hFE, "R9");
    drive(1'b0, 1'b0, 0, 8'h00, "R11");

    // R4: twelve-hour steps
    setClock(8'h51, 8'h59, 8'h59);
    drive(1'b1, 1'b0, 0, 8'h00, "R4");
    put(1, 8'h59); put(0, 8'h59);
    drive(1'b1, 1'b0, 0, 8'h00, "R4");
    setClock(8'h71, 8'h59, 8'h59); put(3, 8'h07); setDate(8'h05, 8'h03, 8'h21);
    drive(1'b1, 1'b0, 0, 8'h00, "R5");

    // R7: February in leap and common years
    setClock(8'h23, 8'h59, 8'h59); setDate(8'h28, 8'h02, 8'h24);
    drive(1'b1, 1'b0, 0, 8'h00, "R7");
    setClock(8'h23, 8'h59, 8'h59);
    drive(1'b1, 1'b0, 0, 8'h00, "R7");
    setClock(8'h23, 8'h59, 8'h59); setDate(8'h28, 8'h02, 8'h23);
    drive(1'b1, 1'b0, 0, 8'h00, "R7");

    // R6: thirty- and thirty-one-day months
    setClock(8'h23, 8'h59, 8'h59); setDate(8'h30, 8'h04, 8'h10);
    drive(1'b1, 1'b0, 0, 8'h00, "R6");
    setClock(8'h23, 8'h59, 8'h59); setDate(8'h30, 8'h01, 8'h10);
    drive(1'b1, 1'b0, 0, 8'h00, "R6");
    setClock(8'h23, 8'h59, 8'h59);
    drive(1'b1, 1'b0, 0, 8'h00, "R6");

    // R10: load and tick in the same cycle
    put(0, 8'h10);
    drive(1'b1, 1'b1, 0, 8'h30, "R10");
    put(0, 8'h59);
    drive(1'b1, 1'b1, 1, 8'h20, "R10");

    // R2 R3: free running across minute boundaries
    setClock(8'h00, 8'h58, 8'h00);
    for (int i = 0; i < 130; i++) drive(1'b1, 1'b0, 0, 8'h00, "R2");
    drive(1'b0, 1'b0, 0, 8'h00, "R11");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule